// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Bank

This block chooses which of sixteen prioritised message buffers takes an incoming CAN frame. A frame parser upstream hands it the identifier, the identifier-format bit, the remote-request bit and the data length code of each complete frame, with a one-cycle valid strobe. Each buffer is configured through ports with an enable, a direction (receive or transmit), a stored identifier, a format bit and a filter mode. Two partial masks are shared by all buffers.

For a data frame the block names the receive buffer that stores it and flags an overrun when a frame with no free home overwrites unread contents. Buffers with the same filter behave as a FIFO, because a buffer that still holds a frame is passed over while a matching empty one exists. For a remote frame the block asks for an automatic reply from the matching transmit buffer. The block tracks which buffers hold unread frames. The consumer frees a buffer with a release strobe.

Top module: `can_rx_filter_bank`

## Requirements
- R1: Among enabled matching receive buffers that are empty, the lowest index is selected.
- R2: A standard frame (format bit 0) compares identifier bits [10:0] only. An extended frame (format bit 1) compares all 29 bits. In the compare modes a buffer matches only when its stored format bit equals the frame's.
- R3: The 2-bit mode field per buffer (bits [2i+1:2i] of the mode bus) is 0 for exact compare, 1 for accept-any frame of either format, 2 for compare under shared mask A, and 3 for compare under shared mask B. Under a mask, only identifier bits whose mask bit is 1 are compared.
- R4: A buffer whose enable bit is 0 never matches.
- R5: An accepted frame marks its buffer full. A full matching buffer is skipped when an empty matching buffer exists.
- R6: When every matching receive buffer is full, the lowest-index one is overwritten. The overrun strobe pulses and that buffer's overrun flag is set.
- R7: A remote frame (RTR 1) is matched only against transmit buffers (direction bit 1). The lowest match raises the reply request with its index, and no acceptance is signalled. A data frame is matched only against receive buffers.
- R8: A frame that matches no buffer gives no acceptance and no reply, and leaves the full and overrun flags unchanged.
- R9: The acceptance or reply strobe is high for exactly one cycle, two clock edges after the edge that samples the frame strobe. The accepted data length code is presented with it.
- R10: A release clears the full and overrun flags of the indexed buffer. A release in the decision cycle is applied before the selection, so the freed buffer counts as empty.
- R11: After reset all strobes are low and no buffer is full or overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_valid_i | input | 1 | One-cycle strobe for a parsed frame |
| frame_id_i | input | 29 | Frame identifier (standard ID in bits [10:0]) |
| frame_ide_i | input | 1 | Frame format: 0 standard, 1 extended |
| frame_rtr_i | input | 1 | Remote frame request |
| frame_dlc_i | input | 4 | Data length code |
| cfg_en_i | input | 16 | Buffer enable bits |
| cfg_tx_i | input | 16 | Buffer direction: 1 transmit, 0 receive |
| cfg_ide_i | input | 16 | Stored format bit per buffer |
| cfg_mode_i | input | 32 | Filter mode, 2 bits per buffer |
| cfg_id_i | input | 464 | Stored identifier, 29 bits per buffer |
| mask_a_i | input | 29 | Shared partial mask A |
| mask_b_i | input | 29 | Shared partial mask B |
| rel_valid_i | input | 1 | Release strobe |
| rel_idx_i | input | 4 | Buffer to release |
| acc_valid_o | output | 1 | Frame accepted |
| acc_idx_o | output | 4 | Accepting buffer |
| acc_ovr_o | output | 1 | Acceptance overwrote an unread frame |
| acc_dlc_o | output | 4 | Data length code of the accepted frame |
| reply_req_o | output | 1 | Automatic reply request |
| reply_idx_o | output | 4 | Transmit buffer to answer with |
| full_o | output | 16 | Buffers holding unread frames |
| ovr_o | output | 16 | Per-buffer overrun flags |

## Verification
Acceptance and release can land in the same cycle on the same buffer. This happens when the consumer frees the only matching buffer while the selection for a new frame is being made. The bench fills a buffer and then asserts its release in the cycle after the frame strobe. It then judges that the frame goes to that buffer with no overrun, that the buffer stays full, and that its overrun flag is cleared.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
    localparam int unsigned ID_W  = 29;
    localparam int unsigned STD_W = 11;

    typedef enum logic [1:0] {
        FLT_EXACT  = 2'd0,
        FLT_ANY    = 2'd1,
        FLT_MASK_A = 2'd2,
        FLT_MASK_B = 2'd3
    } flt_mode_e;
endpackage

// File: rtl/can_id_match.sv
module can_id_match
    import can_flt_pkg::*;
(
    input  logic            en_i,
    input  logic            b_ide_i,
    input  logic [1:0]      mode_i,
    input  logic [ID_W-1:0] b_id_i,
    input  logic [ID_W-1:0] mask_a_i,
    input  logic [ID_W-1:0] mask_b_i,
    input  logic [ID_W-1:0] f_id_i,
    input  logic            f_ide_i,
    output logic            hit_o
);
    logic [ID_W-1:0] width_mask;
    logic [ID_W-1:0] cmp_mask;
    logic [ID_W-1:0] diff;
    flt_mode_e       mode;

    always_comb begin
        mode       = flt_mode_e'(mode_i);
        width_mask = f_ide_i ? {ID_W{1'b1}} : {{(ID_W-STD_W){1'b0}}, {STD_W{1'b1}}};
        case (mode)
            FLT_MASK_A: cmp_mask = mask_a_i;
            FLT_MASK_B: cmp_mask = mask_b_i;
            default:    cmp_mask = {ID_W{1'b1}};
        endcase
        diff  = (b_id_i ^ f_id_i) & cmp_mask & width_mask;
        hit_o = en_i && ((mode == FLT_ANY) || ((b_ide_i == f_ide_i) && (diff == '0)));
    end
endmodule

// File: rtl/can_prio_pick.sv
module can_prio_pick #(
    parameter int unsigned N  = 16,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/can_rx_filter_bank.sv
module can_rx_filter_bank
    import can_flt_pkg::*;
#(
    parameter int unsigned NB = 16,
    localparam int unsigned IW = $clog2(NB)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_valid_i,
    input  logic [ID_W-1:0]    frame_id_i,
    input  logic               frame_ide_i,
    input  logic               frame_rtr_i,
    input  logic [3:0]         frame_dlc_i,
    input  logic [NB-1:0]      cfg_en_i,
    input  logic [NB-1:0]      cfg_tx_i,
    input  logic [NB-1:0]      cfg_ide_i,
    input  logic [2*NB-1:0]    cfg_mode_i,
    input  logic [ID_W*NB-1:0] cfg_id_i,
    input  logic [ID_W-1:0]    mask_a_i,
    input  logic [ID_W-1:0]    mask_b_i,
    input  logic               rel_valid_i,
    input  logic [IW-1:0]      rel_idx_i,
    output logic               acc_valid_o,
    output logic [IW-1:0]      acc_idx_o,
    output logic               acc_ovr_o,
    output logic [3:0]         acc_dlc_o,
    output logic               reply_req_o,
    output logic [IW-1:0]      reply_idx_o,
    output logic [NB-1:0]      full_o,
    output logic [NB-1:0]      ovr_o
);
    typedef struct packed {
        logic          s1_vld;
        logic          s1_rtr;
        logic [3:0]    s1_dlc;
        logic [NB-1:0] s1_hit;
        logic          acc_vld;
        logic [IW-1:0] acc_idx;
        logic          acc_ovr;
        logic [3:0]    acc_dlc;
        logic          rep;
        logic [IW-1:0] rep_idx;
        logic [NB-1:0] full;
        logic [NB-1:0] ovr;
    } st_t;

    st_t st_d, st_q;

    logic [NB-1:0] hit_w;
    logic [NB-1:0] rel_mask;
    logic [NB-1:0] rx_hit, tx_hit, rx_free_hit;
    logic          free_found, any_found, tx_found;
    logic [IW-1:0] free_idx, any_idx, tx_idx;

    // One comparator per buffer
    for (genvar g = 0; g < NB; g++) begin : g_match
        can_id_match u_match (
            .en_i     (cfg_en_i[g]),
            .b_ide_i  (cfg_ide_i[g]),
            .mode_i   (cfg_mode_i[2*g +: 2]),
            .b_id_i   (cfg_id_i[ID_W*g +: ID_W]),
            .mask_a_i (mask_a_i),
            .mask_b_i (mask_b_i),
            .f_id_i   (frame_id_i),
            .f_ide_i  (frame_ide_i),
            .hit_o    (hit_w[g])
        );
    end

    always_comb begin
        rel_mask = '0;
        if (rel_valid_i) rel_mask[rel_idx_i] = 1'b1;
        rx_hit      = st_q.s1_hit & ~cfg_tx_i;
        tx_hit      = st_q.s1_hit & cfg_tx_i;
        rx_free_hit = rx_hit & ~(st_q.full & ~rel_mask);
    end

    can_prio_pick #(.N(NB)) u_pick_free (.req_i(rx_free_hit), .found_o(free_found), .idx_o(free_idx));
    can_prio_pick #(.N(NB)) u_pick_any  (.req_i(rx_hit),      .found_o(any_found),  .idx_o(any_idx));
    can_prio_pick #(.N(NB)) u_pick_tx   (.req_i(tx_hit),      .found_o(tx_found),   .idx_o(tx_idx));

    always_comb begin
        st_d         = st_q;
        st_d.s1_vld  = frame_valid_i;
        st_d.s1_rtr  = frame_rtr_i;
        st_d.s1_dlc  = frame_dlc_i;
        st_d.s1_hit  = hit_w;
        st_d.acc_vld = 1'b0;
        st_d.acc_ovr = 1'b0;
        st_d.rep     = 1'b0;
        st_d.full    = st_q.full & ~rel_mask;
        st_d.ovr     = st_q.ovr & ~rel_mask;
        if (st_q.s1_vld) begin
            if (st_q.s1_rtr) begin
                if (tx_found) begin
                    st_d.rep     = 1'b1;
                    st_d.rep_idx = tx_idx;
                end
            end else if (any_found) begin
                st_d.acc_vld = 1'b1;
                st_d.acc_dlc = st_q.s1_dlc;
                if (free_found) begin
                    st_d.acc_idx = free_idx;
                end else begin
                    st_d.acc_idx      = any_idx;
                    st_d.acc_ovr      = 1'b1;
                    st_d.ovr[any_idx] = 1'b1;
                end
                st_d.full[st_d.acc_idx] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_valid_o = st_q.acc_vld;
    assign acc_idx_o   = st_q.acc_idx;
    assign acc_ovr_o   = st_q.acc_ovr;
    assign acc_dlc_o   = st_q.acc_dlc;
    assign reply_req_o = st_q.rep;
    assign reply_idx_o = st_q.rep_idx;
    assign full_o      = st_q.full;
    assign ovr_o       = st_q.ovr;
endmodule

// File: rtl/can_flt_chk.sv
module can_flt_chk #(
    parameter int unsigned NB = 16,
    localparam int unsigned IW = $clog2(NB)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_valid_i,
    input logic          acc_valid_o,
    input logic [IW-1:0] acc_idx_o,
    input logic          acc_ovr_o,
    input logic          reply_req_o,
    input logic [NB-1:0] full_o
);
    // R7
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid_o && reply_req_o));

    // R9
    acc_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_o |-> $past(frame_valid_i, 2));

    // R9
    reply_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reply_req_o |-> $past(frame_valid_i, 2));

    // R6
    ovr_with_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ovr_o |-> acc_valid_o);

    // R5
    acc_marks_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_o |-> full_o[acc_idx_o]);

    // R1
    single_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(full_o & ~$past(full_o)) <= 1);

    // R8
    fill_needs_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(full_o & ~$past(full_o))) |-> acc_valid_o);
endmodule

bind can_rx_filter_bank can_flt_chk #(.NB(NB)) u_flt_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_valid_i (frame_valid_i),
    .acc_valid_o   (acc_valid_o),
    .acc_idx_o     (acc_idx_o),
    .acc_ovr_o     (acc_ovr_o),
    .reply_req_o   (reply_req_o),
    .full_o        (full_o)
);

// File: tb/tb_can_rx_filter_bank.sv
`timescale 1ns/1ps
module tb_can_rx_filter_bank;
    localparam int NB = 16;
    localparam int IDW = 29;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            frame_valid_i = 1'b0;
    logic [IDW-1:0]  frame_id_i = '0;
    logic            frame_ide_i = 1'b0;
    logic            frame_rtr_i = 1'b0;
    logic [3:0]      frame_dlc_i = '0;
    logic [NB-1:0]   cfg_en_i = '0;
    logic [NB-1:0]   cfg_tx_i = '0;
    logic [NB-1:0]   cfg_ide_i = '0;
    logic [2*NB-1:0] cfg_mode_i = '0;
    logic [IDW*NB-1:0] cfg_id_i = '0;
    logic [IDW-1:0]  mask_a_i = '0;
    logic [IDW-1:0]  mask_b_i = '0;
    logic            rel_valid_i = 1'b0;
    logic [3:0]      rel_idx_i = '0;
    logic            acc_valid_o, acc_ovr_o, reply_req_o;
    logic [3:0]      acc_idx_o, acc_dlc_o, reply_idx_o;
    logic [NB-1:0]   full_o, ovr_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    can_rx_filter_bank dut (.*);

    typedef struct packed {
        logic           rel;
        logic [3:0]     rel_idx;
        logic [IDW-1:0] id;
        logic           ide;
        logic           rtr;
        logic           e_acc;
        logic [3:0]     e_idx;
        logic           e_ovr;
        logic           e_rep;
        logic [3:0]     e_ridx;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd0,  29'h123,     1'b0, 1'b0, 1'b1, 4'd0,  1'b0, 1'b0, 4'd0}, // R2 exact std
        '{1'b0, 4'd0,  29'h123,     1'b0, 1'b0, 1'b1, 4'd15, 1'b0, 1'b0, 4'd0}, // R5 skip full
        '{1'b0, 4'd0,  29'h123,     1'b0, 1'b0, 1'b1, 4'd0,  1'b1, 1'b0, 4'd0}, // R6 overwrite
        '{1'b0, 4'd0,  29'h1ABCDE0, 1'b1, 1'b0, 1'b1, 4'd1,  1'b0, 1'b0, 4'd0}, // R2 exact ext
        '{1'b0, 4'd0,  29'h2A5,     1'b0, 1'b0, 1'b1, 4'd2,  1'b0, 1'b0, 4'd0}, // R3 mask A
        '{1'b0, 4'd0,  29'h5577,    1'b1, 1'b0, 1'b1, 4'd3,  1'b0, 1'b0, 4'd0}, // R3 mask B
        '{1'b0, 4'd0,  29'h55AB,    1'b1, 1'b0, 1'b1, 4'd4,  1'b0, 1'b0, 4'd0}, // R5 FIFO next
        '{1'b0, 4'd0,  29'h55CC,    1'b1, 1'b0, 1'b1, 4'd3,  1'b1, 1'b0, 4'd0}, // R6 FIFO overrun
        '{1'b0, 4'd0,  29'h321,     1'b0, 1'b1, 1'b0, 4'd0,  1'b0, 1'b1, 4'd5}, // R7 reply
        '{1'b0, 4'd0,  29'h321,     1'b0, 1'b0, 1'b1, 4'd15, 1'b1, 1'b0, 4'd0}, // R7 data skips tx
        '{1'b1, 4'd15, 29'h456,     1'b0, 1'b0, 1'b1, 4'd15, 1'b0, 1'b0, 4'd0}, // R4 disabled, R10
        '{1'b0, 4'd0,  29'h0AA,     1'b1, 1'b0, 1'b1, 4'd15, 1'b1, 1'b0, 4'd0}, // R2 format differs
        '{1'b0, 4'd0,  29'h0AA,     1'b0, 1'b0, 1'b1, 4'd7,  1'b0, 1'b0, 4'd0}, // R2 format equal
        '{1'b0, 4'd0,  29'h1A5,     1'b0, 1'b1, 1'b0, 4'd0,  1'b0, 1'b0, 4'd0}  // R7 remote no tx
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_buf(input int i, input bit tx, input bit ide, input logic [1:0] mode,
                           input logic [IDW-1:0] id);
        cfg_en_i[i] = 1'b1;
        cfg_tx_i[i] = tx;
        cfg_ide_i[i] = ide;
        cfg_mode_i[2*i +: 2] = mode;
        cfg_id_i[IDW*i +: IDW] = id;
    endtask

    task automatic release_buf(input logic [3:0] idx);
        @(negedge clk);
        rel_valid_i = 1'b1;
        rel_idx_i = idx;
        @(posedge clk);
        @(negedge clk);
        rel_valid_i = 1'b0;
    endtask

    // Leaves the caller at the sampling point for the result cycle
    task automatic send(input logic [IDW-1:0] id, input bit ide, input bit rtr, input logic [3:0] dlc,
                        input bit collide, input logic [3:0] cidx);
        @(negedge clk);
        frame_valid_i = 1'b1;
        frame_id_i = id;
        frame_ide_i = ide;
        frame_rtr_i = rtr;
        frame_dlc_i = dlc;
        @(posedge clk);
        @(negedge clk);
        frame_valid_i = 1'b0;
        chk(!acc_valid_o && !reply_req_o, "R9 early strobe", {acc_valid_o, reply_req_o}, 0);
        if (collide) begin
            rel_valid_i = 1'b1;
            rel_idx_i = cidx;
        end
        @(posedge clk);
        @(negedge clk);
        rel_valid_i = 1'b0;
    endtask

    task automatic idle_check;
        @(posedge clk);
        @(negedge clk);
        chk(!acc_valid_o && !reply_req_o, "R9 strobe length", {acc_valid_o, reply_req_o}, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        set_buf(0, 1'b0, 1'b0, 2'd0, 29'h123);
        set_buf(1, 1'b0, 1'b1, 2'd0, 29'h1ABCDE0);
        set_buf(2, 1'b0, 1'b0, 2'd2, 29'h200);
        set_buf(3, 1'b0, 1'b1, 2'd3, 29'h5500);
        set_buf(4, 1'b0, 1'b1, 2'd3, 29'h5500);
        set_buf(5, 1'b1, 1'b0, 2'd0, 29'h321);
        set_buf(6, 1'b0, 1'b0, 2'd0, 29'h456);
        cfg_en_i[6] = 1'b0;
        set_buf(7, 1'b0, 1'b0, 2'd0, 29'h0AA);
        set_buf(15, 1'b0, 1'b0, 2'd1, 29'h0);
        mask_a_i = 29'h700;
        mask_b_i = 29'h1FFFFF00;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk(!acc_valid_o && !reply_req_o && !acc_ovr_o, "R11 strobes", {acc_valid_o, reply_req_o, acc_ovr_o}, 0);
        chk(full_o == '0 && ovr_o == '0, "R11 flags", {full_o, ovr_o}, 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            if (VECS[v].rel) release_buf(VECS[v].rel_idx);
            send(VECS[v].id, VECS[v].ide, VECS[v].rtr, 4'd8, 1'b0, 4'd0);
            chk(acc_valid_o == VECS[v].e_acc, "R9 accept strobe", acc_valid_o, VECS[v].e_acc);
            if (VECS[v].e_acc) begin
                chk(acc_idx_o == VECS[v].e_idx, "R1 accept index", acc_idx_o, VECS[v].e_idx);
                chk(acc_ovr_o == VECS[v].e_ovr, "R6 overrun strobe", acc_ovr_o, VECS[v].e_ovr);
            end
            chk(reply_req_o == VECS[v].e_rep, "R7 reply strobe", reply_req_o, VECS[v].e_rep);
            if (VECS[v].e_rep)
                chk(reply_idx_o == VECS[v].e_ridx, "R7 reply index", reply_idx_o, VECS[v].e_ridx);
            idle_check();
        end

        chk(full_o == 16'h809F, "R5 full flags", full_o, 16'h809F);
        chk(ovr_o == 16'h8009, "R6 overrun flags", ovr_o, 16'h8009);

        // R10 release of buffer 0 in the decision cycle of a frame for it
        send(29'h123, 1'b0, 1'b0, 4'd5, 1'b1, 4'd0);
        chk(acc_valid_o && acc_idx_o == 4'd0, "R10 collide index", {acc_valid_o, acc_idx_o}, 5'h10);
        chk(!acc_ovr_o, "R10 collide no overrun", acc_ovr_o, 0);
        chk(acc_dlc_o == 4'd5, "R9 dlc", acc_dlc_o, 5);
        idle_check();
        chk(full_o == 16'h809F, "R10 collide full", full_o, 16'h809F);
        chk(ovr_o == 16'h8008, "R10 collide overrun cleared", ovr_o, 16'h8008);

        // R10 plain release
        release_buf(4'd7);
        chk(full_o == 16'h801F, "R10 release", full_o, 16'h801F);

        // R8 no match once the catch-all buffer is off
        cfg_en_i[15] = 1'b0;
        send(29'h456, 1'b0, 1'b0, 4'd1, 1'b0, 4'd0);
        chk(!acc_valid_o && !reply_req_o, "R8 no strobe", {acc_valid_o, reply_req_o}, 0);
        idle_check();
        chk(full_o == 16'h801F && ovr_o == 16'h8008, "R8 flags kept", {full_o, ovr_o}, {16'h801F, 16'h8008});

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule